// File: doc/BRIEF.md
# Rectangle Fill and Copy Blitter

This block is a small 2D drawing engine for a linear framebuffer. Software programs a set of 32-bit registers with the rectangle geometry, the framebuffer base addresses and line pitches, the pixel depth and a drawing colour, and then writes the command register. That write launches the operation. The engine walks the rectangle pixel by pixel and reads and writes framebuffer words through a simple synchronous memory port with byte enables. It supports solid fills selected by a raster-op byte and screen-to-screen copies.

Copies whose source and destination overlap in memory are handled by per-axis direction bits in the command. When a direction bit is set, the programmed coordinates name the far column or row, and the walk runs backwards on that axis, so no source pixel is overwritten before it has been read. A command that the engine cannot perform is refused: nothing is drawn and a sticky error flag rises.

Top module: `blit_top`

## Requirements
- R1: After reset `busy`, `err`, `mem_rd` and `mem_wr` are low, and the engine performs no memory access until a legal command is written.
- R2: Register byte offsets: 0x00 command, 0x04 mode, 0x08 source x/y, 0x0C destination x/y, 0x10 size, 0x18 colour, 0x30 source base, 0x34 destination base, 0x38 pitches. Coordinates hold x in bits 11:0 and y in bits 27:16. The size register holds width-1 in bits 11:0 and height-1 in bits 27:16. The base registers hold byte address/8. The pitch register holds source pitch/8 in bits 10:0 and destination pitch/8 in bits 26:16, and bit 31 has no effect. A pixel lives at byte base + y*pitch + x*bytes_per_pixel.
- R3: Mode bits 9:8 select the depth: 00 gives 1 byte per pixel, 01 gives 2 and 11 gives 4. Each pixel write enables only that pixel's bytes, so neighbouring bytes in the same word keep their values.
- R4: A fill command has bit 13 = 1 and bits 1:0 = 01. Its raster op in bits 31:24 selects the result: 0x00 writes zero, 0xFF writes all ones, 0xF0 writes the colour register, and 0x5A writes the old destination XOR the colour.
- R5: A copy command has bit 13 = 0, bits 1:0 = 01 and raster op 0xCC. It copies each source pixel to the matching destination pixel.
- R6: Command bit 15 walks x downwards and bit 14 walks y downwards. The programmed source and destination coordinates then name the last column or row. An overlapping copy run in the matching direction leaves the destination equal to the original source image.
- R7: A command with any other raster-op/type combination, bits 1:0 not 01, or a depth of 10 is refused. Busy stays low, memory is unchanged, and `err` goes high and stays high until reset.
- R8: `busy` is high from the cycle after an accepted command write until the last pixel write completes. All register writes made while busy, including command writes, are ignored.
- R9: Solid fills take 2 cycles per pixel. Copies and XOR fills take 4 cycles per pixel, so `busy` stays high for exactly 2*W*H or 4*W*H cycles.
- R10: Read data is taken one cycle after `mem_rd`. `mem_rd` and `mem_wr` are never high together, and each write strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_addr | output | FB_AW-2 | Framebuffer word address |
| mem_rd | output | 1 | Word read strobe, data expected next cycle |
| mem_wr | output | 1 | Word write strobe |
| mem_be | output | 4 | Byte enables for the write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Sticky refused-command flag |

## Verification
The bench targets overlapping copies in both directions. An engine that ignores a direction bit, or that starts at the near corner, smears the first source pixels across the destination, and the byte-exact memory comparison shows this. Sub-word depths at odd lane offsets catch wrong byte enables or shifts, which would corrupt a neighbouring pixel in the same word. XOR fills and the exact busy length expose a missed destination read or a miscounted rectangle. Writes to the colour and destination registers while busy, and illegal raster ops and depths, show whether a design would redraw with altered state or draw something for a refused command.

// File: rtl/blit_pkg.sv
package blit_pkg;

  localparam logic [7:0] OFS_CMD    = 8'h00;
  localparam logic [7:0] OFS_MODE   = 8'h04;
  localparam logic [7:0] OFS_SRCXY  = 8'h08;
  localparam logic [7:0] OFS_DSTXY  = 8'h0C;
  localparam logic [7:0] OFS_SIZE   = 8'h10;
  localparam logic [7:0] OFS_COLOR  = 8'h18;
  localparam logic [7:0] OFS_SBASE  = 8'h30;
  localparam logic [7:0] OFS_DBASE  = 8'h34;
  localparam logic [7:0] OFS_PITCH  = 8'h38;

  localparam logic [7:0] ROP_ZERO = 8'h00;
  localparam logic [7:0] ROP_ONES = 8'hFF;
  localparam logic [7:0] ROP_FG   = 8'hF0;
  localparam logic [7:0] ROP_XOR  = 8'h5A;
  localparam logic [7:0] ROP_COPY = 8'hCC;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PREP, ST_SRD1, ST_SRD2, ST_DRD1, ST_DRD2, ST_WDONE
  } blit_st_e;

  typedef struct packed {
    logic [7:0] rop;
    logic       rev_x;
    logic       rev_y;
    logic       fill;
  } blit_cmd_t;

  // log2 of bytes per pixel for a depth code
  function automatic logic [1:0] depth_shift(input logic [1:0] code);
    case (code)
      2'b01:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [31:0] pix_mask(input logic [1:0] sh);
    case (sh)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [3:0] pix_be(input logic [1:0] sh);
    case (sh)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int FB_AW = 24,
  parameter int CW    = 12,
  parameter int PW    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             reg_we,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output blit_cmd_t        cmd,
  output logic [1:0]       depth_sh,
  output logic [CW-1:0]    src_x,
  output logic [CW-1:0]    src_y,
  output logic [CW-1:0]    dst_x,
  output logic [CW-1:0]    dst_y,
  output logic [CW-1:0]    w_m1,
  output logic [CW-1:0]    h_m1,
  output logic [31:0]      color,
  output logic [FB_AW-4:0] src_base,
  output logic [FB_AW-4:0] dst_base,
  output logic [PW-1:0]    src_pitch,
  output logic [PW-1:0]    dst_pitch,
  output logic             go,
  output logic             err
);

  localparam int BASE_W = FB_AW - 3;

  logic [1:0] depth_code;
  logic       wr_ok, cmd_hit, rop_ok, legal;
  logic [7:0] new_rop;
  logic       new_fill;
  logic       unused_wd;

  assign unused_wd = ^reg_wdata;
  assign wr_ok     = reg_we && !busy;
  assign cmd_hit   = wr_ok && (reg_addr == OFS_CMD);
  assign new_rop   = reg_wdata[31:24];
  assign new_fill  = reg_wdata[13];

  always_comb begin
    if (new_fill)
      rop_ok = (new_rop == ROP_ZERO) || (new_rop == ROP_ONES) ||
               (new_rop == ROP_FG)   || (new_rop == ROP_XOR);
    else
      rop_ok = (new_rop == ROP_COPY);
  end

  assign legal    = rop_ok && (reg_wdata[1:0] == 2'b01) && (depth_code != 2'b10);
  assign go       = cmd_hit && legal;
  assign depth_sh = depth_shift(depth_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd        <= '0;
      depth_code <= 2'b00;
      src_x      <= '0;
      src_y      <= '0;
      dst_x      <= '0;
      dst_y      <= '0;
      w_m1       <= '0;
      h_m1       <= '0;
      color      <= '0;
      src_base   <= '0;
      dst_base   <= '0;
      src_pitch  <= '0;
      dst_pitch  <= '0;
      err        <= 1'b0;
    end else begin
      if (cmd_hit && !legal)
        err <= 1'b1;
      if (go) begin
        cmd.rop   <= new_rop;
        cmd.rev_x <= reg_wdata[15];
        cmd.rev_y <= reg_wdata[14];
        cmd.fill  <= new_fill;
      end
      if (wr_ok) begin
        case (reg_addr)
          OFS_MODE:  depth_code <= reg_wdata[9:8];
          OFS_SRCXY: begin src_x <= reg_wdata[CW-1:0]; src_y <= reg_wdata[16+CW-1:16]; end
          OFS_DSTXY: begin dst_x <= reg_wdata[CW-1:0]; dst_y <= reg_wdata[16+CW-1:16]; end
          OFS_SIZE:  begin w_m1  <= reg_wdata[CW-1:0]; h_m1  <= reg_wdata[16+CW-1:16]; end
          OFS_COLOR: color    <= reg_wdata;
          OFS_SBASE: src_base <= reg_wdata[BASE_W-1:0];
          OFS_DBASE: dst_base <= reg_wdata[BASE_W-1:0];
          OFS_PITCH: begin
            src_pitch <= reg_wdata[PW-1:0];
            dst_pitch <= reg_wdata[16+PW-1:16];
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/blit_axis.sv
module blit_axis #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          rev,
  input  logic [CW-1:0] lim,
  input  logic [CW-1:0] s0,
  input  logic [CW-1:0] d0,
  output logic [CW-1:0] s_cur,
  output logic [CW-1:0] d_cur,
  output logic          at_end
);

  logic [CW-1:0] cnt;

  assign at_end = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      s_cur <= '0;
      d_cur <= '0;
    end else if (load || (step && at_end)) begin
      cnt   <= '0;
      s_cur <= s0;
      d_cur <= d0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
      if (rev) begin
        s_cur <= s_cur - 1'b1;
        d_cur <= d_cur - 1'b1;
      end else begin
        s_cur <= s_cur + 1'b1;
        d_cur <= d_cur + 1'b1;
      end
    end
  end

endmodule

// File: rtl/blit_addr.sv
module blit_addr #(
  parameter int FB_AW = 24,
  parameter int CW    = 12,
  parameter int PW    = 11
) (
  input  logic [FB_AW-4:0] base,
  input  logic [PW-1:0]    pitch,
  input  logic [CW-1:0]    x,
  input  logic [CW-1:0]    y,
  input  logic [1:0]       sh,
  output logic [FB_AW-3:0] word,
  output logic [1:0]       lane
);

  localparam int PRW = CW + PW + 3;

  logic [PRW-1:0]   y_ext, p_ext, row_prod;
  logic [CW+1:0]    col_b;
  logic [FB_AW-1:0] byte_addr;

  assign y_ext     = PRW'(y);
  assign p_ext     = PRW'({pitch, 3'b000});
  assign row_prod  = y_ext * p_ext;
  assign col_b     = {2'b00, x} << sh;
  assign byte_addr = {base, 3'b000} + FB_AW'(row_prod) + FB_AW'(col_b);
  assign word      = byte_addr[FB_AW-1:2];
  assign lane      = byte_addr[1:0];

endmodule

// File: rtl/blit_top.sv
module blit_top
  import blit_pkg::*;
#(
  parameter int FB_AW = 24,
  parameter int CW    = 12,
  parameter int PW    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [FB_AW-3:0] mem_addr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             busy,
  output logic             err
);

  blit_cmd_t        cmd;
  blit_st_e         st;
  logic [1:0]       sh;
  logic [CW-1:0]    sx0, sy0, dx0, dy0, w_m1, h_m1;
  logic [CW-1:0]    sx, sy, dx, dy;
  logic [31:0]      color;
  logic [FB_AW-4:0] sbase, dbase;
  logic [PW-1:0]    spitch, dpitch;
  logic             go, load, step, x_end, y_end, last;
  logic [FB_AW-3:0] src_word, dst_word;
  logic [1:0]       src_lane, dst_lane;
  logic [31:0]      mask, fill_val, src_pix;
  logic [3:0]       dst_be;

  blit_regs #(.FB_AW(FB_AW), .CW(CW), .PW(PW)) u_regs (
    .clk(clk), .rst(rst), .busy(busy),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .cmd(cmd), .depth_sh(sh),
    .src_x(sx0), .src_y(sy0), .dst_x(dx0), .dst_y(dy0),
    .w_m1(w_m1), .h_m1(h_m1), .color(color),
    .src_base(sbase), .dst_base(dbase),
    .src_pitch(spitch), .dst_pitch(dpitch),
    .go(go), .err(err)
  );

  assign load = (st == ST_IDLE) && go;
  assign last = x_end && y_end;
  assign step = (st == ST_WDONE) && !last;

  blit_axis #(.CW(CW)) u_xaxis (
    .clk(clk), .rst(rst), .load(load), .step(step), .rev(cmd.rev_x),
    .lim(w_m1), .s0(sx0), .d0(dx0), .s_cur(sx), .d_cur(dx), .at_end(x_end)
  );

  blit_axis #(.CW(CW)) u_yaxis (
    .clk(clk), .rst(rst), .load(load), .step(step && x_end), .rev(cmd.rev_y),
    .lim(h_m1), .s0(sy0), .d0(dy0), .s_cur(sy), .d_cur(dy), .at_end(y_end)
  );

  blit_addr #(.FB_AW(FB_AW), .CW(CW), .PW(PW)) u_src_addr (
    .base(sbase), .pitch(spitch), .x(sx), .y(sy), .sh(sh),
    .word(src_word), .lane(src_lane)
  );

  blit_addr #(.FB_AW(FB_AW), .CW(CW), .PW(PW)) u_dst_addr (
    .base(dbase), .pitch(dpitch), .x(dx), .y(dy), .sh(sh),
    .word(dst_word), .lane(dst_lane)
  );

  assign mask    = pix_mask(sh);
  assign dst_be  = pix_be(sh) << dst_lane;
  assign src_pix = (mem_rdata >> {src_lane, 3'b000}) & mask;

  always_comb begin
    case (cmd.rop)
      ROP_ONES: fill_val = 32'hFFFF_FFFF;
      ROP_FG:   fill_val = color;
      default:  fill_val = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      busy      <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_be    <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (go) begin
            busy <= 1'b1;
            st   <= ST_PREP;
          end
        end
        ST_PREP: begin
          if (!cmd.fill) begin
            mem_rd   <= 1'b1;
            mem_addr <= src_word;
            st       <= ST_SRD1;
          end else if (cmd.rop == ROP_XOR) begin
            mem_rd   <= 1'b1;
            mem_addr <= dst_word;
            st       <= ST_DRD1;
          end else begin
            mem_wr    <= 1'b1;
            mem_addr  <= dst_word;
            mem_be    <= dst_be;
            mem_wdata <= (fill_val & mask) << {dst_lane, 3'b000};
            st        <= ST_WDONE;
          end
        end
        ST_SRD1: begin
          mem_rd <= 1'b0;
          st     <= ST_SRD2;
        end
        ST_SRD2: begin
          mem_wr    <= 1'b1;
          mem_addr  <= dst_word;
          mem_be    <= dst_be;
          mem_wdata <= src_pix << {dst_lane, 3'b000};
          st        <= ST_WDONE;
        end
        ST_DRD1: begin
          mem_rd <= 1'b0;
          st     <= ST_DRD2;
        end
        ST_DRD2: begin
          mem_wr    <= 1'b1;
          mem_be    <= dst_be;
          mem_wdata <= mem_rdata ^ ((color & mask) << {dst_lane, 3'b000});
          st        <= ST_WDONE;
        end
        ST_WDONE: begin
          mem_wr <= 1'b0;
          if (last) begin
            busy <= 1'b0;
            st   <= ST_IDLE;
          end else begin
            st <= ST_PREP;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/blit_chk.sv
module blit_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       err,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic [3:0] mem_be,
  input logic       reg_we,
  input logic [7:0] reg_addr
);

  a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r10_wr_single: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd && !mem_wr));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    !$fell(err));

  a_r8_busy_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(reg_we) && $past(reg_addr) == 8'h00));

  a_r3_be_width: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                $countones(mem_be) == 4));

endmodule

bind blit_top blit_chk u_blit_chk (
  .clk(clk), .rst(rst), .busy(busy), .err(err),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_be(mem_be),
  .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/blit_top_test.sv
module blit_top_test;

  localparam int FB_AW = 12;
  localparam int NB    = 1 << FB_AW;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reg_we = 1'b0;
  logic [7:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [FB_AW-3:0] mem_addr;
  logic             mem_rd, mem_wr;
  logic [3:0]       mem_be;
  logic [31:0]      mem_wdata;
  logic [31:0]      mem_rdata = '0;
  logic             busy, err;

  logic [7:0] mem_b [0:NB-1];
  logic [7:0] exp_b [0:NB-1];
  logic [7:0] snap  [0:NB-1];

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  blit_top #(.FB_AW(FB_AW)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .err(err)
  );

  // framebuffer model: one-cycle read latency, byte-enabled writes
  always @(posedge clk) begin
    if (mem_rd)
      mem_rdata <= {mem_b[{mem_addr, 2'd3}], mem_b[{mem_addr, 2'd2}],
                    mem_b[{mem_addr, 2'd1}], mem_b[{mem_addr, 2'd0}]};
    for (int l = 0; l < 4; l++)
      if (mem_wr && mem_be[l]) mem_b[{mem_addr, 2'(l)}] <= mem_wdata[8*l +: 8];
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic check_mem(input string tag);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < NB; i++)
      if (mem_b[i] !== exp_b[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: %0d bytes differ, byte %0h actual=%0h expected=%0h",
               tag, bad, first, mem_b[first], exp_b[first]);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  function automatic int bpp_of(input logic [1:0] code);
    return (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 4;
  endfunction

  task automatic set_geom(input logic [1:0] code, input int sbase, input int spitch,
                          input int sx, input int sy, input int dbase, input int dpitch,
                          input int dx, input int dy, input int w, input int h);
    wr_reg(8'h04, 32'(code) << 8);
    wr_reg(8'h08, 32'(sx) | (32'(sy) << 16));
    wr_reg(8'h0C, 32'(dx) | (32'(dy) << 16));
    wr_reg(8'h10, 32'(w - 1) | (32'(h - 1) << 16));
    wr_reg(8'h30, 32'(sbase / 8));
    wr_reg(8'h34, 32'(dbase / 8));
    wr_reg(8'h38, 32'h8000_0000 | 32'(spitch / 8) | (32'(dpitch / 8) << 16));
  endtask

  // solid or XOR fill (R2, R3, R4, R9)
  task automatic t_fill(input string tag, input logic [1:0] code, input logic [7:0] rop,
                        input logic [31:0] fg, input int base, input int pitch,
                        input int x, input int y, input int w, input int h);
    int bpp = bpp_of(code);
    int n;
    set_geom(code, 0, 0, 0, 0, base, pitch, x, y, w, h);
    wr_reg(8'h18, fg);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        for (int k = 0; k < bpp; k++) begin
          int a = base + (y + r) * pitch + (x + c) * bpp + k;
          case (rop)
            8'h00: exp_b[a] = 8'h00;
            8'hFF: exp_b[a] = 8'hFF;
            8'hF0: exp_b[a] = fg[8*k +: 8];
            default: exp_b[a] = exp_b[a] ^ fg[8*k +: 8];
          endcase
        end
    wr_reg(8'h00, (32'(rop) << 24) | 32'h2001);
    check({tag, " R8 busy after launch"}, busy, 1);
    wait_idle(n);
    check({tag, " R9 busy cycles"}, n, (rop == 8'h5A ? 4 : 2) * w * h);
    check_mem({tag, " R2 R3 R4 memory"});
  endtask

  // copy with optional reverse walk (R5, R6); x/y give the low corner
  task automatic t_copy(input string tag, input logic [1:0] code, input logic rx,
                        input logic ry, input int sbase, input int spitch,
                        input int sx, input int sy, input int dbase, input int dpitch,
                        input int dx, input int dy, input int w, input int h);
    int bpp = bpp_of(code);
    int n;
    int ox = rx ? w - 1 : 0;
    int oy = ry ? h - 1 : 0;
    set_geom(code, sbase, spitch, sx + ox, sy + oy, dbase, dpitch, dx + ox, dy + oy, w, h);
    for (int i = 0; i < NB; i++) snap[i] = exp_b[i];
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        for (int k = 0; k < bpp; k++)
          exp_b[dbase + (dy + r) * dpitch + (dx + c) * bpp + k] =
            snap[sbase + (sy + r) * spitch + (sx + c) * bpp + k];
    wr_reg(8'h00, 32'hCC00_0001 | (32'(rx) << 15) | (32'(ry) << 14));
    wait_idle(n);
    check({tag, " R9 busy cycles"}, n, 4 * w * h);
    check_mem({tag, " R5 R6 memory"});
  endtask

  // refused command (R7)
  task automatic t_bad(input string tag, input logic [1:0] code, input logic [31:0] cmdw);
    wr_reg(8'h04, 32'(code) << 8);
    wr_reg(8'h00, cmdw);
    check({tag, " R7 busy stays low"}, busy, 0);
    check({tag, " R7 err raised"}, err, 1);
    repeat (4) @(negedge clk);
    check_mem({tag, " R7 memory unchanged"});
  endtask

  // writes while busy are dropped (R8)
  task automatic t_drop();
    int n;
    set_geom(2'b00, 0, 0, 0, 0, 32'h700, 16, 1, 1, 4, 2);
    wr_reg(8'h18, 32'h11);
    for (int r = 1; r < 3; r++)
      for (int c = 1; c < 5; c++) exp_b[32'h700 + r * 16 + c] = 8'h00;
    wr_reg(8'h00, 32'hF000_2001);
    wr_reg(8'h18, 32'h99);
    wr_reg(8'h0C, 32'h0000_0008);
    wr_reg(8'h00, 32'hFF00_2001);
    wait_idle(n);
    wr_reg(8'h00, 32'h5A00_2001);
    wait_idle(n);
    check_mem("drop R8 colour/dst/cmd writes while busy ignored");
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin
      mem_b[i] = 8'((i * 7 + 3) ^ (i >> 5));
      exp_b[i] = mem_b[i];
    end
    do_reset();
    check("R1 busy after reset", busy, 0);
    check("R1 err after reset", err, 0);
    check("R1 mem_wr after reset", mem_wr, 0);
    check("R1 mem_rd after reset", mem_rd, 0);

    t_fill("fill8",   2'b00, 8'hF0, 32'h0000_00A5, 32'h000, 64, 3, 1, 5, 3);
    t_fill("zero16",  2'b01, 8'h00, 32'h1234_5678, 32'h200, 32, 1, 2, 3, 2);
    t_fill("ones32",  2'b11, 8'hFF, 32'h0,         32'h300, 48, 1, 0, 2, 2);
    t_fill("xor8",    2'b00, 8'h5A, 32'h0000_003C, 32'h000, 64, 2, 5, 6, 1);
    t_fill("fg16",    2'b01, 8'hF0, 32'h0000_BEEF, 32'h280, 16, 3, 1, 3, 2);
    t_copy("copy16",  2'b01, 1'b0, 1'b0, 32'h100, 64, 1, 1, 32'h500, 32, 0, 0, 4, 3);
    t_copy("revx8",   2'b00, 1'b1, 1'b0, 32'h400, 64, 0, 0, 32'h400, 64, 3, 0, 8, 2);
    t_copy("revy32",  2'b11, 1'b0, 1'b1, 32'h600, 32, 0, 0, 32'h600, 32, 0, 1, 2, 3);
    t_copy("revxy16", 2'b01, 1'b1, 1'b1, 32'h480, 32, 0, 0, 32'h480, 32, 1, 1, 3, 2);

    t_drop();

    t_bad("badrop", 2'b00, 32'h3300_2001);
    t_fill("after-err", 2'b00, 8'hF0, 32'h77, 32'h000, 64, 0, 7, 2, 1);
    check("R7 err sticky after good command", err, 1);

    do_reset();
    check("R7 err cleared only by reset", err, 0);
    t_bad("baddepth", 2'b10, 32'hF000_2001);
    do_reset();
    t_bad("copyrop-fill", 2'b00, 32'hCC00_2001);
    do_reset();
    t_bad("badtype", 2'b00, 32'hF000_2002);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule